// File: doc/BRIEF.md
# Staged Clock-Manager Reset Sequencer

This block brings a group of three clock-management units out of reset in a fixed order, then releases the system reset. The first unit is the transmit-data clock unit. It is held in reset first and released first. The receive-data unit follows, then the transmit-status unit. Before the sequencer moves on to the next unit, it waits for the lock indication of the unit it has just released. This prevents an out-of-order release, which would stop the units from locking. After all three units lock, the sequencer waits for the sink-side and source-side clocks-ready flags. When both are set, it drives the active-low system reset high.

The power-on reset is synchronised inside the block. Every asynchronous input is retimed before the state machine uses it. While the system is running, a lost lock indication sends the sequencer back to its first state, and the whole sequence runs again. A 3-bit debug output shows the current step.

Top module: `clkmgr_rst_seq`

## Requirements
- R1: While `por_i` is high, all three unit resets read 1, `sys_rst_n_o` reads 0 and `dbg_state_o` reads 0. Assertion takes effect at once. Release takes effect `SYNC_STAGES` clock edges later.
- R2: `rst_txd_o` is high only in step 0, `rst_rxd_o` only in steps 0 to 2, and `rst_tst_o` only in steps 0 to 4. The units are therefore released in the order transmit-data, receive-data, transmit-status.
- R3: After a restart from the running step, step 0 lasts exactly `HOLD_TXD` cycles (default 4). After power-on it lasts at least that long.
- R4: Step 2 (receive-data unit reset held) lasts exactly `HOLD_RXD` cycles (default 8).
- R5: Step 3 holds until `lock_rxd_i` has been seen. Its length is the lock delay plus the input latency: `SYNC_STAGES` cycles when `SYNC_INPUTS`=1, one cycle otherwise.
- R6: Step 4 (transmit-status unit reset held) lasts exactly `HOLD_TST` cycles (default 12).
- R7: Step 5 holds until `lock_tst_i` has been seen, with the same latency rule as R5.
- R8: Step 6 holds until both `snk_rdy_i` and `src_rdy_i` are seen high. `sys_rst_n_o` is 1 only in step 7.
- R9: In step 7, a low level on any lock input returns the sequencer to step 0 after the input latency. The system reset then goes low and the sequence reruns.
- R10: `dbg_state_o` encodes the steps as 0 transmit-data hold, 1 transmit-data lock wait, 2 receive-data hold, 3 receive-data lock wait, 4 transmit-status hold, 5 transmit-status lock wait, 6 clocks-ready wait, 7 running. Its value only ever advances by one or returns to 0.
- R11: Step 1 holds until `lock_txd_i` has been seen, with the same latency rule as R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| lock_txd_i | input | 1 | Lock indication of the transmit-data clock unit |
| lock_rxd_i | input | 1 | Lock indication of the receive-data clock unit |
| lock_tst_i | input | 1 | Lock indication of the transmit-status clock unit |
| snk_rdy_i | input | 1 | Sink-side clocks-ready flag |
| src_rdy_i | input | 1 | Source-side clocks-ready flag |
| rst_txd_o | output | 1 | Reset to the transmit-data clock unit, active high |
| rst_rxd_o | output | 1 | Reset to the receive-data clock unit, active high |
| rst_tst_o | output | 1 | Reset to the transmit-status clock unit, active high |
| sys_rst_n_o | output | 1 | System reset, active low |
| dbg_state_o | output | 3 | Current step, encoded as in R10 |

## Verification
The hardest situation to reach is a lock lost while the system is running. The bench's clock-unit models only drop lock when their reset is asserted, and in step 7 no reset is asserted. To reach it, the bench forces one unit's lock low at a time, rotating through the three units. It then checks that the restart is taken and that the rerun step-0 hold is exact. A power-on reset injected mid-sequence, in the receive-data lock wait, covers an abort from a state other than running. Lock and ready delays are drawn at random each pass, so every wait step is measured against a fresh, known delay.

// File: rtl/crs_pkg.sv
package crs_pkg;
   typedef enum logic [2:0] {
      ST_TXD_HOLD = 3'd0,
      ST_TXD_WAIT = 3'd1,
      ST_RXD_HOLD = 3'd2,
      ST_RXD_WAIT = 3'd3,
      ST_TST_HOLD = 3'd4,
      ST_TST_WAIT = 3'd5,
      ST_CLK_WAIT = 3'd6,
      ST_RUN      = 3'd7
   } seq_state_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/crs_sync.sv
module crs_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) sh_q <= {STAGES{RST_VAL}};
      else      sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];
endmodule

// File: rtl/crs_in_cond.sv
module crs_in_cond #(
   parameter int WIDTH   = 5,
   parameter int STAGES  = 2,
   parameter bit SYNC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             arst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (SYNC_EN) begin : g_sync
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         crs_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
            .clk (clk),
            .arst(arst),
            .d   (d[i]),
            .q   (q[i])
         );
      end
   end else begin : g_retime
      logic [WIDTH-1:0] r_q;
      always_ff @(posedge clk or posedge arst) begin
         if (arst) r_q <= '0;
         else      r_q <= d;
      end
      assign q = r_q;
   end
endmodule

// File: rtl/crs_hold_cnt.sv
module crs_hold_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         run,
   input  logic [W-1:0] limit,
   output logic         done
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)       cnt_q <= '0;
      else if (!run) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end

   assign done = run && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/clkmgr_rst_seq.sv
module clkmgr_rst_seq
   import crs_pkg::*;
#(
   parameter int HOLD_TXD    = 4,
   parameter int HOLD_RXD    = 8,
   parameter int HOLD_TST    = 12,
   parameter int SYNC_STAGES = 2,
   parameter bit SYNC_INPUTS = 1'b1
) (
   input  logic       clk,
   input  logic       por_i,
   input  logic       lock_txd_i,
   input  logic       lock_rxd_i,
   input  logic       lock_tst_i,
   input  logic       snk_rdy_i,
   input  logic       src_rdy_i,
   output logic       rst_txd_o,
   output logic       rst_rxd_o,
   output logic       rst_tst_o,
   output logic       sys_rst_n_o,
   output logic [2:0] dbg_state_o
);
   localparam int MAX_HOLD = max3(HOLD_TXD, HOLD_RXD, HOLD_TST);
   localparam int CNT_W    = $clog2(MAX_HOLD + 1);
   localparam int N_IN     = 5;

   if (HOLD_TXD < 1 || HOLD_RXD < 1 || HOLD_TST < 1) begin : g_bad_hold
      $error("clkmgr_rst_seq: every hold length must be at least 1");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("clkmgr_rst_seq: SYNC_STAGES must lie in 2..4");
   end

   logic             por_s;
   logic [N_IN-1:0]  in_s;
   seq_state_e       state_q, state_d;
   logic             hold_run, hold_done;
   logic [CNT_W-1:0] hold_lim;
   logic             lk_txd, lk_rxd, lk_tst, snk_ok, src_ok;

   crs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_por_sync (
      .clk (clk),
      .arst(por_i),
      .d   (1'b0),
      .q   (por_s)
   );

   crs_in_cond #(.WIDTH(N_IN), .STAGES(SYNC_STAGES), .SYNC_EN(SYNC_INPUTS)) u_in_cond (
      .clk (clk),
      .arst(por_s),
      .d   ({src_rdy_i, snk_rdy_i, lock_tst_i, lock_rxd_i, lock_txd_i}),
      .q   (in_s)
   );

   assign lk_txd = in_s[0];
   assign lk_rxd = in_s[1];
   assign lk_tst = in_s[2];
   assign snk_ok = in_s[3];
   assign src_ok = in_s[4];

   always_comb begin
      hold_run = 1'b1;
      unique case (state_q)
         ST_TXD_HOLD: hold_lim = CNT_W'(HOLD_TXD);
         ST_RXD_HOLD: hold_lim = CNT_W'(HOLD_RXD);
         ST_TST_HOLD: hold_lim = CNT_W'(HOLD_TST);
         default: begin
            hold_lim = CNT_W'(1);
            hold_run = 1'b0;
         end
      endcase
   end

   crs_hold_cnt #(.W(CNT_W)) u_hold (
      .clk  (clk),
      .rst  (por_s),
      .run  (hold_run),
      .limit(hold_lim),
      .done (hold_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_TXD_HOLD: if (hold_done)          state_d = ST_TXD_WAIT;
         ST_TXD_WAIT: if (lk_txd)             state_d = ST_RXD_HOLD;
         ST_RXD_HOLD: if (hold_done)          state_d = ST_RXD_WAIT;
         ST_RXD_WAIT: if (lk_rxd)             state_d = ST_TST_HOLD;
         ST_TST_HOLD: if (hold_done)          state_d = ST_TST_WAIT;
         ST_TST_WAIT: if (lk_tst)             state_d = ST_CLK_WAIT;
         ST_CLK_WAIT: if (snk_ok && src_ok)   state_d = ST_RUN;
         ST_RUN: if (!(lk_txd && lk_rxd && lk_tst)) state_d = ST_TXD_HOLD;
         default:                             state_d = ST_TXD_HOLD;
      endcase
   end

   always_ff @(posedge clk or posedge por_s) begin
      if (por_s) state_q <= ST_TXD_HOLD;
      else       state_q <= state_d;
   end

   assign rst_txd_o   = (state_q == ST_TXD_HOLD);
   assign rst_rxd_o   = (state_q <= ST_RXD_HOLD);
   assign rst_tst_o   = (state_q <= ST_TST_HOLD);
   assign sys_rst_n_o = (state_q == ST_RUN);
   assign dbg_state_o = state_q;
endmodule

// File: rtl/clkmgr_rst_seq_chk.sv
module clkmgr_rst_seq_chk #(
   parameter int HOLD_RXD = 8,
   parameter int HOLD_TST = 12
) (
   input logic       clk,
   input logic       por_s,
   input logic [2:0] state,
   input logic [2:0] lock_s,
   input logic       snk_s,
   input logic       src_s,
   input logic       rst_txd,
   input logic       rst_rxd,
   input logic       rst_tst,
   input logic       sys_rst_n
);
   int rxd_len, tst_len;

   always_ff @(posedge clk or posedge por_s) begin
      if (por_s) begin
         rxd_len <= 0;
         tst_len <= 0;
      end else begin
         rxd_len <= (state == 3'd2) ? rxd_len + 1 : 0;
         tst_len <= (state == 3'd4) ? tst_len + 1 : 0;
      end
   end

   assert_por_hold_R1: assert property (@(posedge clk)
      por_s |-> (rst_txd && rst_rxd && rst_tst && !sys_rst_n && state == 3'd0));

   assert_release_order_R2: assert property (@(posedge clk) disable iff (por_s)
      (!rst_tst |-> !rst_rxd) and (!rst_rxd |-> !rst_txd));

   assert_rxd_hold_R4: assert property (@(posedge clk) disable iff (por_s)
      $fell(rst_rxd) |-> (rxd_len == HOLD_RXD));

   assert_tst_hold_R6: assert property (@(posedge clk) disable iff (por_s)
      $fell(rst_tst) |-> (tst_len == HOLD_TST));

   assert_txd_wait_R11: assert property (@(posedge clk) disable iff (por_s)
      (state == 3'd1 && !lock_s[0]) |=> (state == 3'd1));

   assert_rxd_wait_R5: assert property (@(posedge clk) disable iff (por_s)
      (state == 3'd3 && !lock_s[1]) |=> (state == 3'd3));

   assert_tst_wait_R7: assert property (@(posedge clk) disable iff (por_s)
      (state == 3'd5 && !lock_s[2]) |=> (state == 3'd5));

   assert_ready_gate_R8: assert property (@(posedge clk) disable iff (por_s)
      $rose(sys_rst_n) |-> $past(snk_s && src_s));

   assert_restart_R9: assert property (@(posedge clk) disable iff (por_s)
      (state == 3'd7 && !(&lock_s)) |=> (state == 3'd0));

   assert_step_R10: assert property (@(posedge clk) disable iff (por_s)
      !$stable(state) |-> (state == 3'($past(state) + 3'd1) || state == 3'd0));
endmodule

bind clkmgr_rst_seq clkmgr_rst_seq_chk #(.HOLD_RXD(HOLD_RXD), .HOLD_TST(HOLD_TST)) u_chk (
   .clk      (clk),
   .por_s    (por_s),
   .state    (state_q),
   .lock_s   (in_s[2:0]),
   .snk_s    (in_s[3]),
   .src_s    (in_s[4]),
   .rst_txd  (rst_txd_o),
   .rst_rxd  (rst_rxd_o),
   .rst_tst  (rst_tst_o),
   .sys_rst_n(sys_rst_n_o)
);

// File: tb/clkmgr_rst_seq_bench.sv
module clkmgr_rst_seq_bench;
   localparam int HOLD_TX = 4;
   localparam int HOLD_RX = 8;
   localparam int HOLD_TS = 12;
   localparam int STAGES  = 2;
   localparam bit SYNC_IN = 1'b1;
   localparam int LAT     = SYNC_IN ? STAGES : 1;

   logic       clk = 1'b0;
   logic       por_i;
   logic [2:0] lk;
   logic       snk_rdy, src_rdy;
   logic       rst_txd, rst_rxd, rst_tst, sys_rst_n;
   logic [2:0] dbg;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   int lk_dly[3];
   int lk_cnt[3];
   bit kill[3];
   int snk_dly, src_dly, rdy_cnt;

   always #5 clk = ~clk;

   clkmgr_rst_seq #(
      .HOLD_TXD(HOLD_TX), .HOLD_RXD(HOLD_RX), .HOLD_TST(HOLD_TS),
      .SYNC_STAGES(STAGES), .SYNC_INPUTS(SYNC_IN)
   ) u_clkmgr_rst_seq (
      .clk        (clk),
      .por_i      (por_i),
      .lock_txd_i (lk[0]),
      .lock_rxd_i (lk[1]),
      .lock_tst_i (lk[2]),
      .snk_rdy_i  (snk_rdy),
      .src_rdy_i  (src_rdy),
      .rst_txd_o  (rst_txd),
      .rst_rxd_o  (rst_rxd),
      .rst_tst_o  (rst_tst),
      .sys_rst_n_o(sys_rst_n),
      .dbg_state_o(dbg)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int wait_len(input int d);
      return d + LAT;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // clock-unit and downstream models plus phase monitor, all at negedge
   initial begin
      logic [2:0] prev;
      int  run_len;
      bit  por_ctx;
      logic [2:0] rst_v;
      prev    = 3'd0;
      run_len = 0;
      por_ctx = 1'b1;
      lk      = 3'b000;
      snk_rdy = 1'b0;
      src_rdy = 1'b0;
      rdy_cnt = 0;
      for (int k = 0; k < 3; k++) lk_cnt[k] = 0;
      forever begin
         @(negedge clk);
         if (done) break;
         rst_v = {rst_tst, rst_rxd, rst_txd};
         if (por_i) begin
            por_ctx = 1'b1;
            chk(rst_v == 3'b111 && !sys_rst_n && dbg == 3'd0, "R1",
                "outputs under power-on reset", {rst_v, sys_rst_n}, 4'b1110);
         end else begin
            chk(rst_txd == (dbg == 3'd0) && rst_rxd == (dbg <= 3'd2) &&
                rst_tst == (dbg <= 3'd4), "R2", "unit resets vs step",
                rst_v, dbg);
            chk(sys_rst_n == (dbg == 3'd7), "R8", "system reset vs step",
                sys_rst_n, dbg == 3'd7);
         end
         if (dbg != prev) begin
            if (dbg == 3'd0) begin
               chk(por_ctx || (prev == 3'd7 && (kill[0] || kill[1] || kill[2])),
                   "R9", "return to step 0 without cause", prev, 7);
            end else begin
               chk(dbg == prev + 3'd1, "R10", "step sequence", dbg, prev + 3'd1);
            end
            if (!(dbg == 3'd0 && por_ctx)) begin
               case (prev)
                  3'd0: if (por_ctx) chk(run_len >= HOLD_TX, "R3", "step 0 after power-on",
                                         run_len, HOLD_TX);
                        else chk(run_len == HOLD_TX, "R3", "step 0 after restart",
                                 run_len, HOLD_TX);
                  3'd1: chk(run_len == wait_len(lk_dly[0]), "R11", "transmit-data lock wait",
                            run_len, wait_len(lk_dly[0]));
                  3'd2: chk(run_len == HOLD_RX, "R4", "receive-data hold", run_len, HOLD_RX);
                  3'd3: chk(run_len == wait_len(lk_dly[1]), "R5", "receive-data lock wait",
                            run_len, wait_len(lk_dly[1]));
                  3'd4: chk(run_len == HOLD_TS, "R6", "transmit-status hold", run_len, HOLD_TS);
                  3'd5: chk(run_len == wait_len(lk_dly[2]), "R7", "transmit-status lock wait",
                            run_len, wait_len(lk_dly[2]));
                  3'd6: chk(run_len == wait_len(max2(snk_dly, src_dly)), "R8",
                            "clocks-ready wait", run_len, wait_len(max2(snk_dly, src_dly)));
                  default: ;
               endcase
            end
            if (prev == 3'd0 && !por_i) por_ctx = 1'b0;
            prev    = dbg;
            run_len = 1;
         end else begin
            run_len++;
         end
         for (int k = 0; k < 3; k++) begin
            if (rst_v[k] || kill[k]) begin
               lk_cnt[k] = 0;
               lk[k]     = 1'b0;
            end else begin
               lk_cnt[k]++;
               if (lk_cnt[k] >= lk_dly[k]) lk[k] = 1'b1;
            end
         end
         if (dbg < 3'd6) begin
            rdy_cnt = 0;
            snk_rdy = 1'b0;
            src_rdy = 1'b0;
         end else begin
            rdy_cnt++;
            if (rdy_cnt >= snk_dly) snk_rdy = 1'b1;
            if (rdy_cnt >= src_dly) src_rdy = 1'b1;
         end
      end
   end

   task automatic wait_step(input logic [2:0] s, input string req);
      int n;
      n = 0;
      while (dbg != s && n < 400) begin
         @(negedge clk);
         n++;
      end
      chk(dbg == s, req, "step reached", dbg, s);
      #1;
   endtask

   task automatic pick_delays(input int mode);
      for (int k = 0; k < 3; k++)
         lk_dly[k] = (mode == 0) ? 1 : int'($urandom_range(16, 1));
      snk_dly = (mode == 0) ? 1 : (mode == 1) ? 20 : int'($urandom_range(16, 1));
      src_dly = (mode == 1) ? 2 : (mode == 0) ? 1 : int'($urandom_range(16, 1));
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd7331);
      por_i = 1'b1;
      for (int k = 0; k < 3; k++) kill[k] = 1'b0;
      pick_delays(2);
      repeat (4) @(negedge clk);
      #1 por_i = 1'b0;
      for (int it = 0; it < 9; it++) begin
         wait_step(3'd7, "R8");
         chk(sys_rst_n == 1'b1, "R8", "system reset released in run", sys_rst_n, 1);
         repeat ($urandom_range(5, 1)) @(negedge clk);
         #1;
         pick_delays(it == 0 ? 0 : it == 1 ? 1 : 2);
         kill[it % 3] = 1'b1;
         wait_step(3'd0, "R9");
         chk(sys_rst_n == 1'b0, "R9", "system reset after lock loss", sys_rst_n, 0);
         kill[it % 3] = 1'b0;
         if (it == 4) begin
            wait_step(3'd3, "R5");
            por_i = 1'b1;
            @(negedge clk);
            chk(rst_txd && rst_rxd && rst_tst && !sys_rst_n && dbg == 3'd0, "R1",
                "mid-sequence power-on reset", dbg, 0);
            repeat (2) @(negedge clk);
            #1 por_i = 1'b0;
         end
      end
      wait_step(3'd7, "R8");
      done = 1'b1;
      @(negedge clk);
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "R10", "watchdog expired", 0, 1);
      done = 1'b1;
      summary();
   end
endmodule